// File: doc/BRIEF.md
# Sensor alignment mode controller

This block holds the mode logic and the serial readout path of a rotary position sensor's digital interface. Chip select is active low. On each falling edge of chip select the block samples a program input and latches one of two modes. A high program input selects alignment mode and a low one selects normal mode. In the same cycle the block captures a frame into a shift register, so the read that follows already reflects the mode just chosen. In normal mode the frame carries the angle word. In alignment mode it carries the magnetic displacement amplitude instead, which is used to centre the magnet over the sensor.

Chip select, the serial clock and the program input are asynchronous to the system clock. Each passes through a two-flop synchronizer, and edges are detected on the synchronized copies. Each frame has the data field, two magnet-status flags and a parity bit. It leaves MSB first and advances one bit per rising edge of the serial clock. In alignment mode, an amplitude below a threshold forces both status flags set and pulls both active-low flag pins low. The block also checks that the program input was stable for a minimum number of system clocks before the chip-select edge that samples it. It raises an error output when that is not so.

Top module: `align_mode_ctrl`

## Requirements
- R1: After reset the block is in normal mode (`align_mode_o`=0), `dout_oe_o`=0, `dout_o`=0 and `setup_err_o`=0.
- R2: A chip-select falling edge while `prog_in` is high puts the block in alignment mode (`align_mode_o`=1).
- R3: A chip-select falling edge while `prog_in` is low returns the block to normal mode (`align_mode_o`=0).
- R4: The frame is FRAME_W = DATA_W+3 bits, sent MSB first: data[DATA_W-1:0], then inc flag, then dec flag, then parity. After the chip-select fall `dout_o` shows the first bit, and each serial-clock rising edge advances one bit. Zeros follow the last bit. In normal mode the data field is `angle_i`.
- R5: In alignment mode the data field is `ampl_i`, taken with the mode chosen at that same chip-select edge.
- R6: In alignment mode with `ampl_i` < THRESH (default 128), both frame flag bits are 1 and both `mag_inc_n_o` and `mag_dec_n_o` are 0.
- R7: In normal mode, and in alignment mode with `ampl_i` >= THRESH, the frame flag bits equal `mag_inc_i`/`mag_dec_i` and the pins are their inverses.
- R8: The parity bit makes the number of ones across the whole frame even.
- R9: The mode changes only on a chip-select falling edge. Program-input changes and chip-select rising edges leave it alone. `dout_oe_o` is 1 only while the synchronized chip select is low, and `dout_o` is 0 whenever `dout_oe_o` is 0.
- R10: `setup_err_o` is updated at every chip-select falling edge. It becomes 1 if the synchronized program input had been stable for fewer than SETUP_CYC system clocks, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| cs_n_in | input | 1 | Asynchronous active-low chip select |
| sclk_in | input | 1 | Asynchronous serial clock |
| prog_in | input | 1 | Asynchronous program input, sampled at chip-select fall |
| angle_i | input | DATA_W | Parallel angle word |
| ampl_i | input | DATA_W | Parallel displacement amplitude |
| mag_inc_i | input | 1 | Magnitude-increase status, active high |
| mag_dec_i | input | 1 | Magnitude-decrease status, active high |
| dout_o | output | 1 | Serial data out |
| dout_oe_o | output | 1 | Output enable for the serial data (high-impedance when 0) |
| mag_inc_n_o | output | 1 | Active-low magnitude-increase pin |
| mag_dec_n_o | output | 1 | Active-low magnitude-decrease pin |
| align_mode_o | output | 1 | Current mode, 1 = alignment |
| setup_err_o | output | 1 | Program-input setup violation at the last chip-select fall |

## Verification
A wrong mode register shows in two places: at the mode output three system clocks after the chip-select input falls, and on the flag pins at once. The first bit of the frame then carries the wrong source word, so a single read exposes it. A corrupted shift register or a stale capture shows within one frame as a wrong data, flag or parity bit. A broken stability counter shows in the error output right after the sampling edge.

// File: rtl/align_mode_ctrl.sv
module align_mode_ctrl #(
  parameter int DATA_W    = 12,
  parameter int THRESH    = 128,
  parameter int SETUP_CYC = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_in,
  input  logic              sclk_in,
  input  logic              prog_in,
  input  logic [DATA_W-1:0] angle_i,
  input  logic [DATA_W-1:0] ampl_i,
  input  logic              mag_inc_i,
  input  logic              mag_dec_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic              mag_inc_n_o,
  output logic              mag_dec_n_o,
  output logic              align_mode_o,
  output logic              setup_err_o
);

  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(SETUP_CYC + 1);
  localparam logic [DATA_W-1:0] THR = DATA_W'(THRESH);
  localparam logic [CNT_W-1:0]  CNT_MAX = CNT_W'(SETUP_CYC);

  logic [2:0] cs_q, sclk_q, prog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= '1;
      sclk_q <= '0;
      prog_q <= '0;
    end else begin
      cs_q   <= {cs_q[1:0], cs_n_in};
      sclk_q <= {sclk_q[1:0], sclk_in};
      prog_q <= {prog_q[1:0], prog_in};
    end
  end

  logic cs_s, prog_s, cs_fall, sclk_rise, prog_chg;
  assign cs_s      = cs_q[1];
  assign prog_s    = prog_q[1];
  assign cs_fall   = cs_q[2] & ~cs_q[1];
  assign sclk_rise = ~sclk_q[2] & sclk_q[1];
  assign prog_chg  = prog_q[2] ^ prog_q[1];

  logic [CNT_W-1:0] stable_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             stable_cnt <= '0;
    else if (prog_chg)      stable_cnt <= '0;
    else if (stable_cnt < CNT_MAX) stable_cnt <= stable_cnt + 1'b1;
  end

  logic align_q, err_q;
  logic mode_nxt;
  assign mode_nxt = cs_fall ? prog_s : align_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      align_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (cs_fall) begin
      align_q <= prog_s;
      err_q   <= prog_chg || (stable_cnt < CNT_MAX);
    end
  end

  logic              low_nxt, inc_nxt, dec_nxt;
  logic [DATA_W-1:0] data_nxt;
  logic [FRAME_W-1:0] frame_nxt, shreg;

  assign low_nxt   = mode_nxt && (ampl_i < THR);
  assign inc_nxt   = low_nxt | mag_inc_i;
  assign dec_nxt   = low_nxt | mag_dec_i;
  assign data_nxt  = mode_nxt ? ampl_i : angle_i;
  assign frame_nxt = {data_nxt, inc_nxt, dec_nxt, ^{data_nxt, inc_nxt, dec_nxt}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  shreg <= '0;
    else if (cs_fall)            shreg <= frame_nxt;
    else if (sclk_rise && !cs_s) shreg <= {shreg[FRAME_W-2:0], 1'b0};
  end

  logic low_now;
  assign low_now = align_q && (ampl_i < THR);

  assign dout_oe_o    = ~cs_s;
  assign dout_o       = dout_oe_o & shreg[FRAME_W-1];
  assign mag_inc_n_o  = ~(low_now | mag_inc_i);
  assign mag_dec_n_o  = ~(low_now | mag_dec_i);
  assign align_mode_o = align_q;
  assign setup_err_o  = err_q;

endmodule

module align_mode_ctrl_chk #(
  parameter int DATA_W = 12,
  parameter int THRESH = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_fall,
  input logic              prog_s,
  input logic              prog_chg,
  input logic [DATA_W-1:0] ampl_i,
  input logic              mag_inc_i,
  input logic              mag_dec_i,
  input logic              align_mode_o,
  input logic              mag_inc_n_o,
  input logic              mag_dec_n_o,
  input logic              dout_o,
  input logic              dout_oe_o,
  input logic              setup_err_o
);

  a_r2_enter_align: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall && prog_s |=> align_mode_o);

  a_r3_exit_align: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall && !prog_s |=> !align_mode_o);

  a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_fall |=> $stable(align_mode_o));

  a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe_o |-> !dout_o);

  a_r6_both_low: assert property (@(posedge clk) disable iff (!rst_n)
    align_mode_o && (ampl_i < DATA_W'(THRESH)) |-> !mag_inc_n_o && !mag_dec_n_o);

  a_r7_pass_normal: assert property (@(posedge clk) disable iff (!rst_n)
    !align_mode_o |-> (mag_inc_n_o != mag_inc_i) && (mag_dec_n_o != mag_dec_i));

  a_r10_setup_err: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall && prog_chg |=> setup_err_o);

endmodule

bind align_mode_ctrl align_mode_ctrl_chk #(.DATA_W(DATA_W), .THRESH(THRESH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .prog_s(prog_s), .prog_chg(prog_chg),
  .ampl_i(ampl_i), .mag_inc_i(mag_inc_i), .mag_dec_i(mag_dec_i),
  .align_mode_o(align_mode_o), .mag_inc_n_o(mag_inc_n_o), .mag_dec_n_o(mag_dec_n_o),
  .dout_o(dout_o), .dout_oe_o(dout_oe_o), .setup_err_o(setup_err_o)
);

// File: tb/align_mode_ctrl_tb.sv
module align_mode_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;
  localparam int SETUP = 100;
  localparam int FW = DW + 3;
  localparam int NVEC = 6;
  // {prog, inc, dec, angle, ampl}
  localparam logic [2*DW+2:0] VEC [0:NVEC-1] = '{
    {1'b0, 1'b1, 1'b0, 12'hA5C, 12'h040},
    {1'b1, 1'b0, 1'b0, 12'h123, 12'h07F},
    {1'b1, 1'b1, 1'b0, 12'h000, 12'h080},
    {1'b1, 1'b0, 1'b1, 12'h3C3, 12'hFFF},
    {1'b1, 1'b0, 1'b0, 12'h555, 12'h000},
    {1'b0, 1'b0, 1'b1, 12'hFFF, 12'h010}
  };

  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, prog = 0, inc = 0, dec = 0;
  logic [DW-1:0] angle = '0, ampl = '0;
  logic dout, oe, inc_n, dec_n, mode, err;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  align_mode_ctrl #(.DATA_W(DW), .THRESH(128), .SETUP_CYC(SETUP)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n), .sclk_in(sclk), .prog_in(prog),
    .angle_i(angle), .ampl_i(ampl), .mag_inc_i(inc), .mag_dec_i(dec),
    .dout_o(dout), .dout_oe_o(oe), .mag_inc_n_o(inc_n), .mag_dec_n_o(dec_n),
    .align_mode_o(mode), .setup_err_o(err));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_frame(output logic [FW-1:0] w);
    cs_n = 0;
    wait_cyc(4);
    w[FW-1] = dout;
    for (int i = FW - 2; i >= 0; i--) begin
      sclk = 1; wait_cyc(4);
      w[i] = dout;
      sclk = 0; wait_cyc(4);
    end
  endtask

  task automatic end_frame();
    sclk = 1; wait_cyc(4);
    chk("R4 zero fill", dout, 0);
    sclk = 0; wait_cyc(4);
    cs_n = 1; wait_cyc(4);
    chk("R9 oe off", oe, 0);
    chk("R9 dout idle", dout, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] w, exp_w;
    logic [DW-1:0] d;
    logic lo, ei, ed;
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(2);
    chk("R1 mode", mode, 0);
    chk("R1 oe", oe, 0);
    chk("R1 dout", dout, 0);
    chk("R1 err", err, 0);

    for (int v = 0; v < NVEC; v++) begin
      {prog, inc, dec, angle, ampl} = VEC[v];
      wait_cyc(SETUP + 4);
      read_frame(w);
      d  = prog ? ampl : angle;
      lo = prog && (ampl < 12'd128);
      ei = lo | inc;
      ed = lo | dec;
      exp_w = {d, ei, ed, ^{d, ei, ed}};
      chk(prog ? "R2 mode enter" : "R3 mode exit", mode, prog);
      chk(prog ? "R5 align frame" : "R4 normal frame", w, exp_w);
      chk(lo ? "R6 flags forced" : "R7 flags pass", {w[2], w[1]}, {ei, ed});
      chk(lo ? "R6 pins low" : "R7 pins", {inc_n, dec_n}, {~ei, ~ed});
      chk("R8 parity even", ^w, 0);
      chk("R10 no err", err, 0);
      chk("R9 oe on", oe, 1);
      end_frame();
    end

    // R9: program input alone does not change mode; cs rise neither
    prog = 1;
    wait_cyc(SETUP + 4);
    chk("R9 prog ignored", mode, 0);
    chk("R9 pins unchanged", {inc_n, dec_n}, 2'b10);
    cs_n = 0; wait_cyc(4);
    chk("R2 enter direct", mode, 1);
    prog = 0; wait_cyc(6);
    cs_n = 1; wait_cyc(4);
    chk("R9 cs rise keeps mode", mode, 1);

    // R10: setup violation, then recovery
    prog = 1; wait_cyc(3);
    cs_n = 0; wait_cyc(4);
    chk("R10 err set", err, 1);
    cs_n = 1;
    wait_cyc(SETUP + 4);
    cs_n = 0; wait_cyc(4);
    chk("R10 err clear", err, 0);
    chk("R2 mode kept align", mode, 1);
    cs_n = 1; wait_cyc(4);

    // R6 live pins follow amplitude in alignment mode
    ampl = 12'd127; inc = 0; dec = 0; wait_cyc(1);
    chk("R6 pins at 127", {inc_n, dec_n}, 2'b00);
    ampl = 12'd128; wait_cyc(1);
    chk("R7 pins at 128", {inc_n, dec_n}, 2'b11);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule